// File: doc/BRIEF.md
# Predicated Byte Gather Load Unit

This block fills a vector of 64-bit result lanes with single bytes read from memory. One start pulse hands it a 64-bit scalar base, a vector of 64-bit index lanes, a per-lane predicate mask and an extension-mode bit. For each enabled lane the unit forms a byte address: the base plus a 64-bit offset built from the low 32 bits of that lane's index. It reads the byte over a simple request/response port and zero-extends it into the lane. Lanes whose predicate bit is clear never reach memory and come back as zero.

Enabled lanes are visited from lane 0 upward, with one read in flight at a time. When every enabled lane has been read, the assembled vector appears on `result_o` in the same cycle as a one-cycle `done_o` pulse. If memory flags an error, the unit stops issuing reads. It then pulses `done_o` together with `fault_o`, reports the faulting lane and leaves `result_o` as it was. The number of lanes is the parameter `VLEN` divided by 64.

Top module: `byte_gather_unit`

## Requirements
- R1: Each enabled lane of `result_o` (lane i at bits i*64+63 down to i*64) holds the byte returned for that lane in bits 7:0, with bits 63:8 zero.
- R2: A lane's read address equals `base_i` plus the extended low 32 bits of its index lane, taken modulo 2^64. Index bits 63:32 have no effect.
- R3: When `sext_i` is 1 the 32-bit offset is sign-extended, and when it is 0 it is zero-extended, before the add.
- R4: A lane whose `pred_i` bit is 0 issues no read, and its result lane is all zeros.
- R5: A lane whose `pred_i` bit is 0 never causes `fault_o`, even if its address would return an error.
- R6: Reads are issued as one-cycle `mem_req_o` pulses in ascending lane order, one per enabled lane. A new read is never issued before the previous one has received `mem_rsp_valid_i`.
- R7: On a response with `mem_rsp_err_i` set, no further reads are issued. `fault_o` is high in the cycle of the `done_o` pulse, `fault_lane_o` gives the lane number, and `result_o` keeps its previous value.
- R8: `start_i` while idle captures all operands. `busy_o` stays high up to and including the single-cycle `done_o` pulse. `start_i` while busy has no effect.
- R9: With an all-zero predicate no read is issued, `done_o` rises two clock edges after the start edge, and `result_o` becomes all zeros.
- R10: The lane count is `VLEN/64`, with `VLEN` from 128 to 2048 in steps of 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a gather (sampled only while idle) |
| base_i | input | 64 | Scalar base address |
| index_i | input | VLEN | Index lanes, lane i in bits i*64+63:i*64 |
| pred_i | input | VLEN/64 | Per-lane enable, bit i for lane i |
| sext_i | input | 1 | 1: sign-extend offsets, 0: zero-extend |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | High with done_o when a read failed |
| fault_lane_o | output | clog2(VLEN/64) | Lane number of the failed read |
| result_o | output | VLEN | Gathered, zero-extended bytes |
| mem_req_o | output | 1 | One-cycle read request |
| mem_addr_o | output | 64 | Byte address of the request |
| mem_rsp_valid_i | input | 1 | Read response strobe |
| mem_rsp_data_i | input | 8 | Returned byte |
| mem_rsp_err_i | input | 1 | Response carries an error |

## Verification
On every cycle the assertions check these invariants: the single outstanding read, that each read and any fault belong to an enabled lane, and that the operands stay frozen while busy. They also check the single-cycle done pulse, that `result_o` changes only at a successful done, and the two-edge path for an empty predicate. The address arithmetic, the extension mode, and the ascending lane order cannot be seen as invariants. The same holds for the zero-extension of each byte and the content of the result. The bench scenarios show these by comparison with a reference model: random predicates, offsets with bit 31 set, a base that wraps past 2^64, errors placed on enabled and disabled lanes, and a second start issued while the unit is busy.

// File: rtl/gather_pkg.sv
package gather_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_WAIT   = 2'd2,
        ST_FINISH = 2'd3
    } gstate_e;

    function automatic logic [63:0] widen_offset(input logic [31:0] off, input logic sx);
        return sx ? {{32{off[31]}}, off} : {32'd0, off};
    endfunction

endpackage

// File: rtl/gather_lane_pick.sv
module gather_lane_pick #(
    parameter int LANES = 4,
    localparam int IDXW = $clog2(LANES)
) (
    input  logic [LANES-1:0] mask_i,
    output logic             any_o,
    output logic [IDXW-1:0]  lane_o
);
    always_comb begin
        lane_o = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (mask_i[i]) lane_o = IDXW'(i);
        end
        any_o = |mask_i;
    end
endmodule

// File: rtl/gather_addr_gen.sv
module gather_addr_gen #(
    parameter int LANES = 4,
    localparam int IDXW = $clog2(LANES)
) (
    input  logic [63:0]         base_i,
    input  logic [LANES*64-1:0] index_i,
    input  logic [IDXW-1:0]     lane_i,
    input  logic                sext_i,
    output logic [63:0]         addr_o
);
    import gather_pkg::*;

    logic [31:0] low_half [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_low
        assign low_half[g] = index_i[g*64 +: 32];
    end

    logic [31:0] sel_off;

    always_comb begin
        sel_off = '0;
        for (int i = 0; i < LANES; i++) begin
            if (lane_i == IDXW'(i)) sel_off = low_half[i];
        end
        addr_o = base_i + widen_offset(sel_off, sext_i);
    end
endmodule

// File: rtl/byte_gather_unit.sv
module byte_gather_unit #(
    parameter int VLEN = 256,
    localparam int LANES = VLEN / 64,
    localparam int IDXW = $clog2(LANES)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                start_i,
    input  logic [63:0]         base_i,
    input  logic [VLEN-1:0]     index_i,
    input  logic [LANES-1:0]    pred_i,
    input  logic                sext_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                fault_o,
    output logic [IDXW-1:0]     fault_lane_o,
    output logic [VLEN-1:0]     result_o,
    output logic                mem_req_o,
    output logic [63:0]         mem_addr_o,
    input  logic                mem_rsp_valid_i,
    input  logic [7:0]          mem_rsp_data_i,
    input  logic                mem_rsp_err_i
);
    import gather_pkg::*;

    typedef struct packed {
        gstate_e          st;
        logic [63:0]      base;
        logic [VLEN-1:0]  idx;
        logic [LANES-1:0] pred;
        logic [LANES-1:0] pend;
        logic             sext;
        logic [IDXW-1:0]  cur;
        logic [VLEN-1:0]  scratch;
        logic [VLEN-1:0]  result;
        logic             fault;
        logic [IDXW-1:0]  flane;
    } regs_t;

    regs_t q, d;

    logic            pick_any;
    logic [IDXW-1:0] pick_lane;
    logic [63:0]     lane_addr;

    gather_lane_pick #(.LANES(LANES)) u_pick (
        .mask_i (q.pend),
        .any_o  (pick_any),
        .lane_o (pick_lane)
    );

    gather_addr_gen #(.LANES(LANES)) u_addr (
        .base_i  (q.base),
        .index_i (q.idx),
        .lane_i  (pick_lane),
        .sext_i  (q.sext),
        .addr_o  (lane_addr)
    );

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st      = ST_ISSUE;
                    d.base    = base_i;
                    d.idx     = index_i;
                    d.pred    = pred_i;
                    d.pend    = pred_i;
                    d.sext    = sext_i;
                    d.scratch = '0;
                    d.fault   = 1'b0;
                end
            end
            ST_ISSUE: begin
                if (pick_any) begin
                    d.cur = pick_lane;
                    d.st  = ST_WAIT;
                end else begin
                    d.result = q.scratch;
                    d.st     = ST_FINISH;
                end
            end
            ST_WAIT: begin
                if (mem_rsp_valid_i) begin
                    if (mem_rsp_err_i) begin
                        d.fault = 1'b1;
                        d.flane = q.cur;
                        d.st    = ST_FINISH;
                    end else begin
                        for (int i = 0; i < LANES; i++) begin
                            if (q.cur == IDXW'(i)) begin
                                d.scratch[i*64 +: 64] = {56'd0, mem_rsp_data_i};
                                d.pend[i]             = 1'b0;
                            end
                        end
                        d.st = ST_ISSUE;
                    end
                end
            end
            ST_FINISH: begin
                d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign busy_o       = (q.st != ST_IDLE);
    assign done_o       = (q.st == ST_FINISH);
    assign fault_o      = (q.st == ST_FINISH) && q.fault;
    assign fault_lane_o = q.flane;
    assign result_o     = q.result;
    assign mem_req_o    = (q.st == ST_ISSUE) && pick_any;
    assign mem_addr_o   = lane_addr;

endmodule

// File: rtl/gather_checker.sv
module gather_checker #(
    parameter int LANES = 4,
    localparam int IDXW = $clog2(LANES)
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                start_i,
    input logic [LANES-1:0]    pred_i,
    input logic                busy_o,
    input logic                done_o,
    input logic                fault_o,
    input logic [IDXW-1:0]     fault_lane_o,
    input logic [LANES*64-1:0] result_o,
    input logic                mem_req_o,
    input logic                mem_rsp_valid_i,
    input logic [LANES-1:0]    pred_q,
    input logic [63:0]         base_q,
    input logic [IDXW-1:0]     pick_lane
);
    logic in_flight;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              in_flight <= 1'b0;
        else if (mem_req_o)       in_flight <= 1'b1;
        else if (mem_rsp_valid_i) in_flight <= 1'b0;
    end

    AST_ONE_IN_FLIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_flight |-> !mem_req_o); // R6
    AST_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_req_o |=> !mem_req_o); // R6
    AST_REQ_ENABLED_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_req_o |-> pred_q[pick_lane]); // R4
    AST_FAULT_ENABLED_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o |-> pred_q[fault_lane_o]); // R5
    AST_FAULT_KEEPS_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o |-> (done_o && $stable(result_o))); // R7
    AST_RESULT_ONLY_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(result_o) |-> (done_o && !fault_o)); // R1
    AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> busy_o ##1 !done_o); // R8
    AST_OPERANDS_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |=> ($stable(base_q) && $stable(pred_q))); // R8
    AST_EMPTY_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o && pred_i == '0) |=> (!mem_req_o ##1 done_o)); // R9
endmodule

bind byte_gather_unit gather_checker #(.LANES(LANES)) u_gather_checker (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .start_i         (start_i),
    .pred_i          (pred_i),
    .busy_o          (busy_o),
    .done_o          (done_o),
    .fault_o         (fault_o),
    .fault_lane_o    (fault_lane_o),
    .result_o        (result_o),
    .mem_req_o       (mem_req_o),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .pred_q          (q.pred),
    .base_q          (q.base),
    .pick_lane       (pick_lane)
);

// File: tb/test_byte_gather_unit.sv
module test_byte_gather_unit;
    localparam int CLK_PERIOD = 10;
    localparam int VLEN  = 256;
    localparam int LANES = VLEN / 64;
    localparam int IDXW  = $clog2(LANES);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [63:0] base = '0;
    logic [VLEN-1:0] index = '0;
    logic [LANES-1:0] pred = '0;
    logic sext = 1'b0;
    logic busy, done, fault;
    logic [IDXW-1:0] fault_lane;
    logic [VLEN-1:0] result;
    logic mem_req;
    logic [63:0] mem_addr;
    logic rsp_valid = 1'b0;
    logic [7:0] rsp_data = '0;
    logic rsp_err = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_gather_unit #(.VLEN(VLEN)) i_byte_gather_unit (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_i(base),
        .index_i(index), .pred_i(pred), .sext_i(sext), .busy_o(busy),
        .done_o(done), .fault_o(fault), .fault_lane_o(fault_lane),
        .result_o(result), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
        .mem_rsp_valid_i(rsp_valid), .mem_rsp_data_i(rsp_data), .mem_rsp_err_i(rsp_err)
    );

    int errors = 0;
    int checks = 0;
    logic [63:0] err_addr = '0;
    logic err_en = 1'b0;
    logic [63:0] exp_q[$];
    logic [VLEN-1:0] last_good = '0;
    int wait_cnt = 0;
    logic [63:0] held_addr = '0;

    function automatic logic [7:0] mem_byte(input logic [63:0] a);
        return a[7:0] ^ a[15:8] ^ a[39:32] ^ a[63:56] ^ 8'h5a;
    endfunction

    task automatic check(input bit ok, input string req, input logic [VLEN-1:0] act,
                         input logic [VLEN-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // memory responder and per-cycle request comparison
    always @(negedge clk) begin
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        if (wait_cnt > 0) begin
            wait_cnt--;
            if (wait_cnt == 0) begin
                rsp_valid = 1'b1;
                rsp_data  = mem_byte(held_addr);
                rsp_err   = err_en && (held_addr == err_addr);
            end
        end
        if (mem_req) begin
            check(wait_cnt == 0 && !rsp_valid, "R6 overlapping request", VLEN'(wait_cnt), '0);
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected request", VLEN'(mem_addr), '0);
            end else begin
                check(mem_addr == exp_q[0], "R2/R3/R6 request address",
                      VLEN'(mem_addr), VLEN'(exp_q[0]));
                void'(exp_q.pop_front());
            end
            held_addr = mem_addr;
            wait_cnt  = 1 + int'($urandom % 3);
        end
    end

    int cycle_count = 0;
    always @(posedge clk) begin
        cycle_count++;
        if (cycle_count > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<150000", cycle_count);
            finish_run();
        end
    end

    task automatic run_op(input logic [63:0] b, input logic [VLEN-1:0] ix,
                          input logic [LANES-1:0] p, input logic sx,
                          input bit disturb, output int latency);
        logic [VLEN-1:0] exp_res;
        bit exp_fault;
        int exp_lane;
        int cyc;
        exp_res = '0;
        exp_fault = 0;
        exp_lane = 0;
        exp_q.delete();
        for (int i = 0; i < LANES; i++) begin
            if (p[i] && !exp_fault) begin
                logic [31:0] off;
                logic [63:0] a;
                off = ix[i*64 +: 32];
                a = b + (sx ? {{32{off[31]}}, off} : {32'd0, off});
                exp_q.push_back(a);
                if (err_en && a == err_addr) begin
                    exp_fault = 1;
                    exp_lane = i;
                end else begin
                    exp_res[i*64 +: 64] = {56'd0, mem_byte(a)};
                end
            end
        end
        if (exp_fault) exp_res = last_good;

        @(negedge clk);
        start = 1'b1; base = b; index = ix; pred = p; sext = sx;
        @(negedge clk);
        if (disturb) begin
            // R8: second start while busy with different operands
            check(busy, "R8 busy after start", VLEN'(busy), 1);
            base = ~b; index = ~ix; pred = ~p; sext = ~sx;
            @(negedge clk);
        end
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 400) begin
            @(negedge clk);
            cyc++;
        end
        latency = cyc + (disturb ? 2 : 1);
        check(done, "R8 done reached", VLEN'(done), 1);
        check(busy, "R8 busy with done", VLEN'(busy), 1);
        check(fault == exp_fault, "R5/R7 fault flag", VLEN'(fault), VLEN'(exp_fault));
        if (exp_fault)
            check(fault_lane == IDXW'(exp_lane), "R7 fault lane", VLEN'(fault_lane), VLEN'(exp_lane));
        check(result == exp_res, "R1/R4 result vector", result, exp_res);
        check(exp_q.size() == 0, "R6 missing requests", VLEN'(exp_q.size()), '0);
        if (!exp_fault) last_good = exp_res;
        @(negedge clk);
        check(!done && !busy, "R8 single done pulse", VLEN'({done, busy}), '0);
        exp_q.delete();
    endtask

    initial begin
        int lat;
        logic [VLEN-1:0] ix;
        repeat (3) @(negedge clk);
        check(!busy && !done && !mem_req && result == '0, "R8 reset state", result, '0);
        rst_n = 1'b1;

        // R1/R2: all lanes, zero-extension, upper index bits set
        for (int i = 0; i < LANES; i++) ix[i*64 +: 64] = {32'hdead_beef, 32'(i * 17 + 3)};
        run_op(64'h0000_1000_0000_0000, ix, '1, 1'b0, 0, lat);

        // R3: offsets with bit 31 set, both modes
        for (int i = 0; i < LANES; i++) ix[i*64 +: 64] = {32'h1234_5678, 32'h8000_0000 + 32'(i * 5)};
        run_op(64'h0000_0002_0000_0000, ix, '1, 1'b1, 0, lat);
        run_op(64'h0000_0002_0000_0000, ix, '1, 1'b0, 0, lat);

        // R2: base near top wraps modulo 2^64
        for (int i = 0; i < LANES; i++) ix[i*64 +: 64] = {32'h0, 32'h10 + 32'(i)};
        run_op(64'hffff_ffff_ffff_fff8, ix, '1, 1'b0, 0, lat);

        // R9: empty predicate, two edges to done, zero result
        run_op(64'h55, ix, '0, 1'b1, 0, lat);
        check(lat == 2, "R9 empty latency", VLEN'(lat), 2);

        // R5: error address on a disabled lane never faults
        for (int i = 0; i < LANES; i++) ix[i*64 +: 64] = {32'h0, 32'h100 * 32'(i + 1)};
        err_en = 1'b1;
        err_addr = 64'h4000 + 64'h200;
        run_op(64'h4000, ix, LANES'(4'b1101), 1'b0, 0, lat);

        // R7: error on enabled lane 2 stops the gather, result unchanged
        err_addr = 64'h4000 + 64'h300;
        run_op(64'h4000, ix, '1, 1'b0, 0, lat);
        err_en = 1'b0;

        // R8: start while busy is ignored
        run_op(64'h8000, ix, LANES'(4'b1010), 1'b1, 1, lat);

        // R10 / random mix of predicates, modes and offsets
        for (int n = 0; n < 40; n++) begin
            for (int i = 0; i < LANES; i++) ix[i*64 +: 64] = {$urandom, $urandom};
            err_en = (n % 5 == 4);
            err_addr = 64'h7000_0000 + {32'h0, ix[(n % LANES)*64 +: 32]};
            run_op(64'h7000_0000, ix, LANES'($urandom), 1'(n & 1), 0, lat);
        end
        finish_run();
    end
endmodule